// File: doc/BRIEF.md
# Two-Level Interrupt Acceptance Controller

This block decides, every clock, whether any pending interrupt may break into the code that is running. Each vectored source sits in one of two groups, chosen by a per-source bit in a 16-bit priority-flag register. A nesting stack records the level of every handler that is active. The level on top of the stack decides which requests may nest. A separate status register holds a flag that blocks a second nonmaskable interrupt (NMI) until the first handler returns.

A request marked for macro service does not start a CPU handler. It is accepted whatever its group and whatever level is active, and it does not touch the nesting stack. The CPU sequencer gets a one-cycle accept strobe and the index of the winning source. It signals the end of a handler with a return strobe.

Software reaches both registers through a small byte-addressed bus. Each write is either a whole byte or a single bit. In single-bit mode, a bit position is given and the value is taken from data bit 0.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, the priority flags read 0xFF at address 0 and at address 1, and the status register at address 2 reads 0x00. Address 3 always reads 0x00 and ignores writes.
- R2: Priority flag value 0 puts a source in the high group and 1 puts it in the low group. Address 0 holds sources 7..0 and address 1 holds sources 15..8, with bit k of a byte belonging to source 8*addr+k. A byte write (`reg_bit_i`=0) loads all eight flags. A bit write (`reg_bit_i`=1) loads only flag `reg_bitpos_i`, taking its value from `reg_wdata_i[0]`.
- R3: The status register keeps the NMI flag in bit 1, and its other bits always read 0. A byte write loads the flag from data bit 1. A bit write with position 1 loads the flag from data bit 0.
- R4: With no handler active, or with a low-group handler on top, any requesting vectored source is accepted when `ie_i` is 1. No vectored request is accepted while `ie_i` is 0.
- R5: With a high-group handler on top, only high-group sources are accepted as nested handlers. While an NMI handler is on top, no vectored handler is accepted.
- R6: A request whose macro-service bit is set is accepted at any level and in either group, provided `ie_i` is 1 (the stack being full does not block it). It pushes nothing onto the stack.
- R7: Among eligible vectored requests, the high group wins over the low group. Within a group, the lowest index wins.
- R8: An NMI request is accepted whenever the NMI flag is 0, regardless of `ie_i`, the active level or vectored requests. An accepted NMI sets the flag and pushes the NMI level onto the stack. While the flag is 1, no NMI is accepted.
- R9: A return strobe pops one stack level and clears the NMI flag when the popped level is an NMI. A return with an empty stack changes nothing. No request is accepted in a cycle with a return strobe.
- R10: The stack holds 8 levels. When it is full, neither an NMI nor a vectored handler is accepted.
- R11: The accept strobe rises in the clock after the request is sampled and lasts one cycle per accepted request. `accept_src_o` carries the winner's index in that same cycle. For an NMI, `accept_nmi_o` is 1 and the index is 0. With no accept, both `accept_nmi_o` and the index are 0.
- R12: When an accept, a return and a software write affect the NMI flag in the same cycle, the accept or return decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Vectored request lines |
| ms_i | input | 16 | Macro-service marker per source |
| nmi_i | input | 1 | NMI request |
| ie_i | input | 1 | Global enable for vectored requests |
| reti_i | input | 1 | Return-from-handler strobe |
| reg_addr_i | input | 2 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_bit_i | input | 1 | 1 selects single-bit write |
| reg_bitpos_i | input | 3 | Bit position for single-bit write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| accept_o | output | 1 | One-cycle accept strobe |
| accept_nmi_o | output | 1 | Accepted request is the NMI |
| accept_src_o | output | 4 | Index of the accepted vectored source |

## Verification
A wrong stack top or a wrong stack count shows only when a request arrives while a handler is active. It appears as an accept where a block was expected, or the reverse. The bench therefore nests handlers of both groups, fills the stack and returns through it. A corrupted NMI flag shows in the next status read. It also shows at the next NMI, which is wrongly accepted or wrongly refused. Priority-flag faults show in the next read of that byte, or as a different winning index when groups are mixed. A reference model is compared against every output on every clock, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_NMI  = 2'd3
    } lvl_e;
endpackage

// File: rtl/irq_flag_regs.sv
module irq_flag_regs #(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic               bit_i,
    input  logic [2:0]         bitpos_i,
    input  logic [7:0]         wdata_i,
    input  logic               nmis_set_i,
    input  logic               nmis_clr_i,
    output logic [7:0]         rdata_o,
    output logic [NUM_SRC-1:0] prio_o,
    output logic               nmis_o
);
    localparam int PRIO_BYTES = (NUM_SRC + 7) / 8;
    localparam int STAT_ADDR  = PRIO_BYTES;
    localparam int FLAG_BIT   = 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] prio;
        logic               nmis;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            for (int b = 0; b < PRIO_BYTES; b++) begin
                if (addr_i == ADDR_W'(b)) begin
                    for (int k = 0; k < 8; k++) begin
                        if (b * 8 + k < NUM_SRC) begin
                            if (bit_i) begin
                                if (bitpos_i == 3'(k)) regs_d.prio[b*8+k] = wdata_i[0];
                            end else begin
                                regs_d.prio[b*8+k] = wdata_i[k];
                            end
                        end
                    end
                end
            end
            if (addr_i == ADDR_W'(STAT_ADDR)) begin
                if (bit_i) begin
                    if (bitpos_i == 3'(FLAG_BIT)) regs_d.nmis = wdata_i[0];
                end else begin
                    regs_d.nmis = wdata_i[FLAG_BIT];
                end
            end
        end
        // hardware events override a concurrent software write
        if (nmis_clr_i) regs_d.nmis = 1'b0;
        if (nmis_set_i) regs_d.nmis = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.prio <= '1;
            regs_q.nmis <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        for (int b = 0; b < PRIO_BYTES; b++) begin
            if (addr_i == ADDR_W'(b)) begin
                for (int k = 0; k < 8; k++) begin
                    if (b * 8 + k < NUM_SRC) rdata_o[k] = regs_q.prio[b*8+k];
                end
            end
        end
        if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o[FLAG_BIT] = regs_q.nmis;
    end

    assign prio_o = regs_q.prio;
    assign nmis_o = regs_q.nmis;

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmis_set_i |=> nmis_o);

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmis_clr_i && !nmis_set_i) |=> !nmis_o);
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
    import irq_accept_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  lvl_e push_lvl_i,
    input  logic pop_i,
    output lvl_e top_o,
    output logic full_o,
    output logic popped_nmi_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        lvl_e [DEPTH-1:0] lvl;
        logic [CNT_W-1:0] cnt;
    } stk_t;

    stk_t stk_d, stk_q;
    logic             empty;
    logic [IDX_W-1:0] top_idx;

    assign empty   = (stk_q.cnt == '0);
    assign full_o  = (stk_q.cnt == CNT_W'(DEPTH));
    assign top_idx = IDX_W'(stk_q.cnt - 1'b1);
    assign top_o   = empty ? LV_NONE : stk_q.lvl[top_idx];
    assign popped_nmi_o = pop_i && !empty && (stk_q.lvl[top_idx] == LV_NMI);

    always_comb begin
        stk_d = stk_q;
        if (pop_i) begin
            if (!empty) stk_d.cnt = stk_q.cnt - 1'b1;
        end else if (push_i && !full_o) begin
            stk_d.lvl[IDX_W'(stk_q.cnt)] = push_lvl_i;
            stk_d.cnt = stk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q.lvl <= '{default: LV_NONE};
            stk_q.cnt <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    // R10
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R9
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_accept_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int SRC_W   = 4
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] ms_i,
    input  logic               nmi_i,
    input  logic               ie_i,
    input  logic               reti_i,
    input  logic [NUM_SRC-1:0] prio_i,
    input  logic               nmis_i,
    input  lvl_e               top_i,
    input  logic               full_i,
    output logic               gnt_o,
    output logic               gnt_nmi_o,
    output logic [SRC_W-1:0]   gnt_idx_o,
    output logic               push_o,
    output lvl_e               push_lvl_o
);
    logic [NUM_SRC-1:0] elig, hi_elig, lo_elig;
    logic [SRC_W-1:0]   hi_idx, lo_idx;
    logic               nest_ok_lo, nest_ok_hi;

    // which group may open a nested handler at the current level
    assign nest_ok_lo = !full_i && (top_i == LV_NONE || top_i == LV_LOW);
    assign nest_ok_hi = !full_i && (top_i == LV_NONE || top_i == LV_LOW || top_i == LV_HIGH);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = req_i[i] && ie_i &&
                         (ms_i[i] || (prio_i[i] ? nest_ok_lo : nest_ok_hi));
    end

    assign hi_elig = elig & ~prio_i;
    assign lo_elig = elig & prio_i;

    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hi_elig[i]) hi_idx = SRC_W'(i);
            if (lo_elig[i]) lo_idx = SRC_W'(i);
        end
    end

    always_comb begin
        gnt_o      = 1'b0;
        gnt_nmi_o  = 1'b0;
        gnt_idx_o  = '0;
        push_o     = 1'b0;
        push_lvl_o = LV_NONE;
        if (!reti_i) begin
            if (nmi_i && !nmis_i && !full_i) begin
                gnt_o      = 1'b1;
                gnt_nmi_o  = 1'b1;
                push_o     = 1'b1;
                push_lvl_o = LV_NMI;
            end else if (|hi_elig) begin
                gnt_o      = 1'b1;
                gnt_idx_o  = hi_idx;
                push_o     = !ms_i[hi_idx];
                push_lvl_o = LV_HIGH;
            end else if (|lo_elig) begin
                gnt_o      = 1'b1;
                gnt_idx_o  = lo_idx;
                push_o     = !ms_i[lo_idx];
                push_lvl_o = LV_LOW;
            end
        end
    end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 2,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] ms_i,
    input  logic               nmi_i,
    input  logic               ie_i,
    input  logic               reti_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic               reg_bit_i,
    input  logic [2:0]         reg_bitpos_i,
    input  logic [7:0]         reg_wdata_i,
    output logic [7:0]         reg_rdata_o,
    output logic               accept_o,
    output logic               accept_nmi_o,
    output logic [SRC_W-1:0]   accept_src_o
);
    typedef struct packed {
        logic             acc;
        logic             nmi;
        logic [SRC_W-1:0] src;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_SRC-1:0] prio;
    logic               nmis, full, popped_nmi;
    lvl_e               top_lvl, push_lvl;
    logic               gnt, gnt_nmi, push;
    logic [SRC_W-1:0]   gnt_idx;

    irq_flag_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .bit_i      (reg_bit_i),
        .bitpos_i   (reg_bitpos_i),
        .wdata_i    (reg_wdata_i),
        .nmis_set_i (gnt && gnt_nmi),
        .nmis_clr_i (popped_nmi),
        .rdata_o    (reg_rdata_o),
        .prio_o     (prio),
        .nmis_o     (nmis)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .req_i      (req_i),
        .ms_i       (ms_i),
        .nmi_i      (nmi_i),
        .ie_i       (ie_i),
        .reti_i     (reti_i),
        .prio_i     (prio),
        .nmis_i     (nmis),
        .top_i      (top_lvl),
        .full_i     (full),
        .gnt_o      (gnt),
        .gnt_nmi_o  (gnt_nmi),
        .gnt_idx_o  (gnt_idx),
        .push_o     (push),
        .push_lvl_o (push_lvl)
    );

    irq_nest_stack #(.DEPTH(DEPTH)) u_stk (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .push_lvl_i   (push_lvl),
        .pop_i        (reti_i),
        .top_o        (top_lvl),
        .full_o       (full),
        .popped_nmi_o (popped_nmi)
    );

    always_comb begin
        out_d.acc = gnt;
        out_d.nmi = gnt && gnt_nmi;
        out_d.src = (gnt && !gnt_nmi) ? gnt_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign accept_o     = out_q.acc;
    assign accept_nmi_o = out_q.nmi;
    assign accept_src_o = out_q.src;

    // R8
    nmi_flag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && gnt_nmi) |-> !nmis);

    // R8
    nmi_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_nmi_o |-> nmis);

    // R5
    high_level_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !gnt_nmi && !ms_i[gnt_idx] && top_lvl == LV_HIGH) |-> !prio[gnt_idx]);

    // R9
    reti_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !accept_o);

    // R11
    nmi_flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_nmi_o |-> (accept_o && accept_src_o == '0));
endmodule

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0, ms = '0;
    logic        nmi = 1'b0, ie = 1'b0, reti = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0, bitm = 1'b0;
    logic [2:0]  bpos = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        acc, acc_nmi;
    logic [3:0]  src;

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";
    bit done = 0;

    // reference model state
    bit [15:0] m_prio;
    bit        m_nmis;
    int        stk[$];
    bit        e_acc, e_nmi;
    int        e_src;

    always #10 clk = ~clk;

    irq_accept_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ms_i(ms), .nmi_i(nmi), .ie_i(ie),
        .reti_i(reti), .reg_addr_i(addr), .reg_wr_i(wr), .reg_bit_i(bitm),
        .reg_bitpos_i(bpos), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .accept_o(acc), .accept_nmi_o(acc_nmi), .accept_src_o(src)
    );

    function automatic int mread(int a);
        if (a == 0) return int'(m_prio[7:0]);
        if (a == 1) return int'(m_prio[15:8]);
        if (a == 2) return m_nmis ? 2 : 0;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prio = 16'hFFFF; m_nmis = 0; stk.delete();
            e_acc = 0; e_nmi = 0; e_src = 0;
        end else begin
            int top;
            bit full, found, nset, nclr;
            top = (stk.size() > 0) ? stk[stk.size()-1] : 0;
            full = (stk.size() == 8);
            e_acc = 0; e_nmi = 0; e_src = 0; nset = 0; nclr = 0; found = 0;
            if (!reti) begin
                if (nmi && !m_nmis && !full) begin
                    e_acc = 1; e_nmi = 1; nset = 1; stk.push_back(3);
                end else begin
                    for (int g = 0; g < 2; g++)
                        for (int i = 0; i < NS; i++)
                            if (!found && req[i] && ie && int'(m_prio[i]) == g) begin
                                bit ok;
                                ok = ms[i] || (!full && (top == 0 || top == 1 || (top == 2 && g == 0)));
                                if (ok) begin
                                    found = 1; e_acc = 1; e_src = i;
                                    if (!ms[i]) stk.push_back(g == 0 ? 2 : 1);
                                end
                            end
                end
            end else if (stk.size() > 0) begin
                if (stk.pop_back() == 3) nclr = 1;
            end
            if (wr) begin
                if (addr < 2) begin
                    for (int k = 0; k < 8; k++)
                        if (!bitm) m_prio[int'(addr)*8+k] = wdata[k];
                        else if (int'(bpos) == k) m_prio[int'(addr)*8+k] = wdata[0];
                end else if (addr == 2) begin
                    if (!bitm) m_nmis = wdata[1];
                    else if (bpos == 3'd1) m_nmis = wdata[0];
                end
            end
            if (nclr) m_nmis = 0;
            if (nset) m_nmis = 1;
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("accept", int'(acc), int'(e_acc));
            cmp("accept_nmi", int'(acc_nmi), int'(e_nmi));
            cmp("src", int'(src), e_src);
            cmp("rdata", int'(rdata), mread(int'(addr)));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk); #2;
        req = '0; ms = '0; nmi = 0; reti = 0; wr = 0; bitm = 0;
    endtask

    task automatic wreg(int a, bit b, int pos, int d);
        addr = 2'(a); wr = 1; bitm = b; bpos = 3'(pos); wdata = 8'(d);
        tick();
    endtask

    task automatic rets(int n);
        for (int i = 0; i < n; i++) begin reti = 1; tick(); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        // R1 reset values through each address
        tag = "R1";
        for (int a = 0; a < 4; a++) begin addr = 2'(a); tick(); end
        wreg(3, 0, 0, 8'h5A); addr = 3; tick();
        // R4 enable gating and idle acceptance
        tag = "R4"; ie = 0; req = 16'h0010; tick(); ms = 16'h0010; req = 16'h0010; tick();
        ie = 1; req = 16'h0010; tick(); tick();
        req = 16'h0100; tick(); tick();  // nested in low handler
        rets(2);
        // R2 byte and bit writes
        tag = "R2"; wreg(1, 0, 0, 8'hF7); wreg(0, 1, 5, 0); wreg(0, 1, 2, 1);
        addr = 0; tick(); addr = 1; tick();
        // R7 ordering
        tag = "R7"; req = 16'h0828; tick(); tick(); rets(1);
        req = 16'h0808; tick(); tick(); rets(1);
        req = 16'h0600; tick(); tick(); rets(1);
        // R5 high level admits only the high group
        tag = "R5"; req = 16'h0020; tick(); tick();
        req = 16'h0008; tick(); tick();
        req = 16'h0800; tick(); tick(); rets(2);
        req = 16'h0008; tick(); req = 16'h0010; tick(); req = 16'h0020; tick();
        req = 16'h0040; tick(); tick(); rets(3);
        // R6 macro service bypasses the level
        tag = "R6"; req = 16'h0020; tick();
        req = 16'h0008; ms = 16'h0008; tick(); tick();
        ie = 0; req = 16'h0008; ms = 16'h0008; tick(); tick(); ie = 1;
        rets(1);
        tag = "R9"; rets(2); req = 16'h0008; reti = 1; tick(); tick();
        // R8 NMI handling
        tag = "R8"; ie = 0; addr = 2; nmi = 1; tick(); tick();
        nmi = 1; tick(); tick();
        ie = 1; req = 16'h0020; tick(); tick();
        req = 16'h0020; ms = 16'h0020; tick(); tick();
        rets(1); ie = 0; nmi = 1; req = 16'h0001; tick(); tick(); ie = 1; rets(1);
        // R3 status register access
        tag = "R3"; wreg(2, 1, 1, 1); tick(); nmi = 1; tick(); tick();
        wreg(2, 0, 0, 8'hFD); wreg(2, 0, 0, 8'hFF); wreg(2, 1, 0, 1); wreg(2, 1, 1, 0); tick();
        // R12 events over writes
        tag = "R12"; nmi = 1; wr = 1; addr = 2; wdata = 8'h00; tick(); tick();
        reti = 1; wr = 1; addr = 2; wdata = 8'h02; tick(); tick();
        // R10 stack capacity
        tag = "R10";
        for (int i = 0; i < 9; i++) begin req = 16'h0008; tick(); end
        nmi = 1; tick(); tick();
        req = 16'h0004; tick(); tick();
        req = 16'h0008; ms = 16'h0008; tick(); tick();
        rets(9); tick();
        // R11 mixed traffic against the model
        tag = "R11";
        for (int n = 0; n < 3000; n++) begin
            req = 16'($urandom & $urandom & $urandom);
            ms = req & 16'($urandom & $urandom);
            nmi = ($urandom % 16) == 0;
            ie = ($urandom % 8) != 0;
            reti = ($urandom % 5) == 0;
            wr = ($urandom % 10) == 0;
            addr = 2'($urandom);
            bitm = 1'($urandom);
            bpos = 3'($urandom);
            wdata = 8'($urandom);
            @(negedge clk); #2;
        end
        tick(); tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule